// File: doc/BRIEF.md
# Three-Port Basic-Mode Parallel I/O Controller

This block gives a host three byte-wide parallel ports (A, B and C) behind a small register window. The host bus carries a 2-bit offset, a write strobe, a read strobe and separate 8-bit write and read data paths. Offsets 0, 1 and 2 select ports A, B and C. Offset 3 is the control word, which sets the direction of each pin group. Port A and port B are each one group. Port C is split into two groups of four bits, and each of them has its own direction.

Every port has an output latch. The latch value is always present on `pin_out`. A per-pin `pin_oe` vector tells the pad logic which pins are driven, so the block itself has no tri-state nets. A control write changes the direction setup only when its top bit is 1. Such a write is a configuration command: it also clears every output latch to zero. Reads are registered, and each read bit reports the latch or the pin, depending on the direction of that bit.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, all 24 pins are outputs (`pin_oe` = 0xFFFFFF) and `pin_out` is 0.
- R2: A write at offset 0, 1 or 2 stores `bus_wdata` in the latch of port A (pins 7:0), port B (pins 15:8) or port C (pins 23:16). The new value is on `pin_out` after the next clock edge.
- R3: A write at offset 3 with bit 7 = 1 is a configuration command, and it sets the directions from the clock edge that takes it. Bit 4 = 1 makes port A an input. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes pins 19:16 (the low nibble of C) an input. Bit 3 = 1 makes pins 23:20 (the high nibble of C) an input. A direction bit of 0 makes its group an output. Bits 6, 5 and 2 have no effect.
- R4: A write at offset 3 with bit 7 = 0 changes neither the directions nor any latch.
- R5: A configuration command clears all three output latches to 0.
- R6: A write to a port whose group is an input still stores the byte in the latch, and the latch value is visible on `pin_out`.
- R7: A read strobe at offset 0, 1 or 2 loads `bus_rdata` at the next clock edge. Each bit holds the latch bit if that bit is an output, and the `pin_in` bit if it is an input.
- R8: A read at offset 3 returns 0x00.
- R9: Each bit of `pin_oe` is 1 exactly when that pin's group is an output.
- R10: The two nibbles of port C keep independent directions, so one read of port C can combine latch bits and pin bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | External pin levels |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The hardest case to reach from the ports is a port C read in which one nibble reports latch bits and the other reports pin bits. The stimulus first issues a configuration command that makes only one nibble an input. It then writes a port C value whose two nibbles differ from `pin_in`, and reads C back. A second command then swaps the two nibbles. This shows the cleared latch on one nibble and the pin value on the other. Writes with bit 7 clear are placed between known configurations, so that any change to the directions or latches shows up on `pin_oe` and `pin_out`.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NPORT  = 3;

   typedef enum logic [1:0] {
      OFS_A   = 2'd0,
      OFS_B   = 2'd1,
      OFS_C   = 2'd2,
      OFS_CTL = 2'd3
   } ofs_e;

   // control word bit positions
   localparam int unsigned CFG_BIT  = 7;
   localparam int unsigned A_IN_BIT = 4;
   localparam int unsigned CH_IN_BIT = 3;
   localparam int unsigned B_IN_BIT = 1;
   localparam int unsigned CL_IN_BIT = 0;

   typedef struct packed {
      logic a_in;
      logic b_in;
      logic ch_in;
      logic cl_in;
   } dir_t;
endpackage

// File: rtl/ppio_dir_reg.sv
module ppio_dir_reg
   import ppio_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [DW-1:0] wdata,
   output dir_t          dir,
   output logic          cfg_cmd
);
   assign cfg_cmd = ctl_wr & wdata[CFG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir <= '0;
      end else if (cfg_cmd) begin
         dir.a_in  <= wdata[A_IN_BIT];
         dir.b_in  <= wdata[B_IN_BIT];
         dir.ch_in <= wdata[CH_IN_BIT];
         dir.cl_in <= wdata[CL_IN_BIT];
      end
   end

   // R4
   nocfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wdata[CFG_BIT]) |=> $stable(dir));

   // R3
   cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[CFG_BIT]) |=>
         (dir.a_in == $past(wdata[A_IN_BIT]) && dir.cl_in == $past(wdata[CL_IN_BIT])));
endmodule

// File: rtl/ppio_port_latch.sv
module ppio_port_latch #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (wr)  q <= wdata;
   end

   // R2
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> (q == $past(wdata)));

   // R5
   latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
   import ppio_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 3
) (
   input  logic [1:0]       ofs,
   input  logic [NP*DW-1:0] lat,
   input  logic [NP*DW-1:0] pins,
   input  logic [NP*DW-1:0] oe,
   output logic [DW-1:0]    rdata
);
   logic [NP*DW-1:0] mix;

   assign mix = (lat & oe) | (pins & ~oe);

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NP; p++) begin
         if (ofs == 2'(p)) rdata = mix[p*DW +: DW];
      end
   end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NP*DW-1:0]    pin_in,
   output logic [NP*DW-1:0]    pin_out,
   output logic [NP*DW-1:0]    pin_oe
);
   localparam int unsigned NPIN = NP * DW;
   localparam int unsigned HALF = DW / 2;

   generate
      if (DW != BYTE_W) begin : g_bad_dw
         $error("ppio_ctrl: DW must be 8, the control word layout is fixed");
      end
      if (NP != NPORT) begin : g_bad_np
         $error("ppio_ctrl: NP must be 3");
      end
   endgenerate

   dir_t        dir;
   logic        cfg_cmd;
   logic        ctl_wr;
   logic [DW-1:0] rd_next;

   assign ctl_wr = bus_wr && (bus_addr == OFS_CTL);

   ppio_dir_reg #(.DW(DW)) i_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_wr),
      .wdata   (bus_wdata),
      .dir     (dir),
      .cfg_cmd (cfg_cmd)
   );

   genvar gp;
   generate
      for (gp = 0; gp < NP; gp++) begin : g_port
         ppio_port_latch #(.W(DW)) i_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_cmd),
            .wr    (bus_wr && (bus_addr == 2'(gp))),
            .wdata (bus_wdata),
            .q     (pin_out[gp*DW +: DW])
         );
      end
   endgenerate

   assign pin_oe[DW-1:0]            = {DW{~dir.a_in}};
   assign pin_oe[2*DW-1:DW]         = {DW{~dir.b_in}};
   assign pin_oe[2*DW+HALF-1:2*DW]  = {HALF{~dir.cl_in}};
   assign pin_oe[NPIN-1:2*DW+HALF]  = {HALF{~dir.ch_in}};

   ppio_rd_mux #(.DW(DW), .NP(NP)) i_rmux (
      .ofs   (bus_addr),
      .lat   (pin_out),
      .pins  (pin_in),
      .oe    (pin_oe),
      .rdata (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   // R8
   ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_CTL) |=> (bus_rdata == '0));

   // R6
   in_port_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_A && dir.a_in) |=> (pin_out[DW-1:0] == $past(bus_wdata)));

   // R9
   oe_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[CFG_BIT]) |=> (pin_oe[DW] == !$past(bus_wdata[B_IN_BIT])));

   // R1
   reset_chk: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '1 && pin_out == '0));
endmodule

// File: tb/test_ppio_ctrl.sv
module test_ppio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out;
   logic [23:0] pin_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ppio_ctrl i_ppio_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] r;
      check("R1 oe", pin_oe, 24'hFFFFFF);
      check("R1 out", pin_out, 24'h0);
      pin_in = 24'h0000AA;
      bus_read(2'd0, r);
      check("R7 read output A", {16'h0, r}, 24'h0);
   endtask

   task automatic t_port_write();
      logic [7:0] r;
      bus_write(2'd0, 8'h5A);
      bus_write(2'd1, 8'hC3);
      bus_write(2'd2, 8'h96);
      check("R2 out", pin_out, 24'h96C35A);
      bus_read(2'd1, r);
      check("R7 read B latch", {16'h0, r}, 24'hC3);
   endtask

   task automatic t_cfg_inputs();
      logic [7:0] r;
      pin_in = 24'h123456;
      bus_write(2'd3, 8'h92);
      check("R9 oe A,B in", pin_oe, 24'hFF0000);
      check("R5 latches cleared", pin_out, 24'h0);
      bus_read(2'd0, r);
      check("R7 read A pins", {16'h0, r}, 24'h56);
      bus_read(2'd1, r);
      check("R7 read B pins", {16'h0, r}, 24'h34);
      bus_read(2'd2, r);
      check("R7 read C latch", {16'h0, r}, 24'h0);
   endtask

   task automatic t_ignored_bits();
      bus_write(2'd3, 8'hE4);
      check("R3 unused bits", pin_oe, 24'hFFFFFF);
   endtask

   task automatic t_nibbles();
      logic [7:0] r;
      pin_in = 24'h123456;
      bus_write(2'd3, 8'h81);
      check("R3 C low in", pin_oe, 24'hF0FFFF);
      bus_write(2'd2, 8'hAB);
      check("R6 C latch", {16'h0, pin_out[23:16]}, 24'hAB);
      bus_read(2'd2, r);
      check("R10 mixed C", {16'h0, r}, 24'hA2);
      bus_write(2'd3, 8'h88);
      check("R3 C high in", pin_oe, 24'h0FFFFF);
      bus_read(2'd2, r);
      check("R10 swapped C", {16'h0, r}, 24'h10);
   endtask

   task automatic t_no_cfg();
      bus_write(2'd3, 8'h81);
      bus_write(2'd0, 8'h77);
      bus_write(2'd3, 8'h1F);
      check("R4 oe kept", pin_oe, 24'hF0FFFF);
      check("R4 latch kept", {16'h0, pin_out[7:0]}, 24'h77);
   endtask

   task automatic t_input_store();
      logic [7:0] r;
      pin_in = 24'h123456;
      bus_write(2'd3, 8'h90);
      bus_write(2'd0, 8'h3C);
      check("R9 A oe off", {16'h0, pin_oe[7:0]}, 24'h0);
      check("R6 stored while input", {16'h0, pin_out[7:0]}, 24'h3C);
      bus_read(2'd0, r);
      check("R7 input read", {16'h0, r}, 24'h56);
   endtask

   task automatic t_ctl_read();
      logic [7:0] r;
      bus_read(2'd3, r);
      check("R8 control read", {16'h0, r}, 24'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_port_write();
      t_cfg_inputs();
      t_ignored_bits();
      t_nibbles();
      t_no_cfg();
      t_input_store();
      t_ctl_read();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule